// File: doc/BRIEF.md
# Block-Scaled 4-Bit Float Weight Expander

This unit sits in front of a half-precision matrix engine. Weights arrive as 4-bit floats (1 sign bit, 2 exponent bits, 1 mantissa bit), two to a byte. Groups of them share a scale. The unit turns each weight into an FP16 value and hands the results downstream one per cycle.

Two grouping schemes go through one datapath. In exponent mode, 32 weights share one byte that holds a bare power-of-two exponent. In FP8 mode, 16 weights share an FP8 (E4M3) byte. On top of that, every product is multiplied by a 32-bit float that applies to the whole tensor. That tensor-wide factor is a static configuration input and must be stable while a stream is in flight.

Both sides are valid/ready streams. A byte moves when `in_valid` and `in_ready` are both high at a clock edge. An FP16 result moves when `out_valid` and `out_ready` are both high. While the output is stalled, the result on it is held, and input bytes are accepted only when there is room.

Top module: `fp4_block_dequant`

## Requirements
- R1: Weight codes 0..7 (bits [2:0] of a nibble) give magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 and 6. Nibble bit 3 is the sign. A negative zero weight gives FP16 0x8000.
- R2: Every data byte carries two weights. Bits [3:0] are emitted before bits [7:4].
- R3: Each group opens with one scale byte, followed by 16 data bytes in exponent mode or 8 data bytes in FP8 mode. `mode_i` (0 = exponent, 1 = FP8) is sampled only in the cycle its scale byte is accepted, so changing it while data bytes flow has no effect.
- R4: In exponent mode the result is weight × 2^(s−127), where s is the scale byte taken as unsigned.
- R5: An exponent-mode scale of 0xFF makes every result of that group the FP16 quiet NaN 0x7E00.
- R6: In FP8 mode the result is weight × E4M3(scale) × FP32(tensor_scale_i). E4M3 has exponent bias 7, scale bits [6:3] are the exponent, bits [2:0] the mantissa and bit 7 the sign, and exponent 0 is subnormal. A scale with bits [6:0] = 0x7F, or a tensor scale whose exponent field is all ones, yields 0x7E00. The sign of the result is the XOR of the three sign bits.
- R7: Narrowing to FP16 rounds to nearest, ties to even, on a grid no finer than 2^-24. A result that rounds to zero becomes a zero carrying the result's sign.
- R8: A result whose magnitude rounds above 65504 saturates to 0x7BFF or 0xFBFF. An infinity is never produced.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No result is lost, duplicated or reordered under any pattern of stalls on either side.
- R10: After reset, `out_valid` is low and `in_ready` is high, awaiting a scale byte.
- R11: With input always valid and `out_ready` always high, the results of one group leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Group mode, sampled with each scale byte: 0 exponent, 1 FP8 |
| tensor_scale_i | input | 32 | Tensor-wide FP32 factor used in FP8 mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Scale byte or two packed weights |
| out_valid | output | 1 | FP16 result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 16 | FP16 result |

## Verification
The hardest situation to reach is the handover at the last high nibble of a group. There, the next byte is a scale, and the output may be stalled in the same cycle, so framing, mode sampling and back-pressure all meet. The bench gets there by streaming several groups of both modes back to back while a pseudo-random sequence gates both `in_valid` and `out_ready`. During that run it flips `mode_i` on every data byte. Rounding ties and the ends of the FP16 range are reached with chosen tensor scales and scale bytes whose exact products sit on a halfway point, on the smallest subnormal, or just past 65504.

// File: rtl/fp4dq_pkg.sv
package fp4dq_pkg;

  typedef enum logic {
    MODE_EXP = 1'b0,
    MODE_FP8 = 1'b1
  } scale_mode_e;

  localparam logic [15:0] HALF_QNAN   = 16'h7E00;
  localparam logic [14:0] HALF_MAXMAG = 15'h7BFF;

  // weight magnitude in units of one half
  function automatic logic [3:0] e2m1_halves(input logic [2:0] code);
    case (code)
      3'd0: return 4'd0;
      3'd1: return 4'd1;
      3'd2: return 4'd2;
      3'd3: return 4'd3;
      3'd4: return 4'd4;
      3'd5: return 4'd6;
      3'd6: return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/fp4dq_ctrl.sv
module fp4dq_ctrl
  import fp4dq_pkg::*;
#(
  parameter int EXP_GROUP = 32,
  parameter int FP8_GROUP = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_i,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        adv_i,
  output logic        emit_o,
  output logic [3:0]  nib_o,
  output logic [7:0]  scale_o,
  output scale_mode_e mode_o
);
  localparam int EXP_BYTES = EXP_GROUP / 2;
  localparam int FP8_BYTES = FP8_GROUP / 2;
  localparam int MAX_BYTES = (EXP_BYTES > FP8_BYTES) ? EXP_BYTES : FP8_BYTES;
  localparam int CW        = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  typedef enum logic [1:0] {ST_SCALE, ST_BYTE, ST_LO, ST_HI} st_e;

  st_e         st_q;
  logic [7:0]  scale_q, byte_q;
  scale_mode_e mode_q;
  logic [CW-1:0] cnt_q;
  logic        last_byte, take;

  assign last_byte = (mode_q == MODE_FP8) ? (cnt_q == CW'(FP8_BYTES - 1))
                                          : (cnt_q == CW'(EXP_BYTES - 1));
  assign emit_o    = (st_q == ST_LO) || (st_q == ST_HI);
  assign nib_o     = (st_q == ST_HI) ? byte_q[7:4] : byte_q[3:0];
  assign scale_o   = scale_q;
  assign mode_o    = mode_q;
  assign in_ready  = (st_q == ST_SCALE) || (st_q == ST_BYTE) || ((st_q == ST_HI) && adv_i);
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SCALE;
      scale_q <= 8'h00;
      byte_q  <= 8'h00;
      mode_q  <= MODE_EXP;
      cnt_q   <= '0;
    end else begin
      case (st_q)
        ST_SCALE: if (take) begin
          scale_q <= in_data;
          mode_q  <= scale_mode_e'(mode_i);
          cnt_q   <= '0;
          st_q    <= ST_BYTE;
        end
        ST_BYTE: if (take) begin
          byte_q <= in_data;
          st_q   <= ST_LO;
        end
        ST_LO: if (adv_i) st_q <= ST_HI;
        default: if (adv_i) begin
          if (last_byte) begin
            if (take) begin
              scale_q <= in_data;
              mode_q  <= scale_mode_e'(mode_i);
              cnt_q   <= '0;
              st_q    <= ST_BYTE;
            end else begin
              st_q <= ST_SCALE;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
            if (take) begin
              byte_q <= in_data;
              st_q   <= ST_LO;
            end else begin
              st_q <= ST_BYTE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fp4dq_scale.sv
module fp4dq_scale
  import fp4dq_pkg::*;
(
  input  scale_mode_e        mode_i,
  input  logic [3:0]         nib_i,
  input  logic [7:0]         scale_i,
  input  logic [31:0]        tensor_i,
  output logic               sign_o,
  output logic               nan_o,
  output logic [31:0]        sig_o,
  output logic signed [11:0] exp_o
);
  logic [3:0]  w_sig;
  logic [3:0]  s_exp, s_sig;
  logic [7:0]  t_exp;
  logic [23:0] t_sig;
  logic signed [11:0] s_x, t_x;

  always_comb begin
    w_sig = e2m1_halves(nib_i[2:0]);
    s_exp = {1'b0, scale_i[6:3]} == 4'd0 ? 4'd1 : {1'b0, scale_i[5:3]} | {scale_i[6], 3'b0};
    s_sig = {|scale_i[6:3], scale_i[2:0]};
    t_exp = (tensor_i[30:23] == 8'd0) ? 8'd1 : tensor_i[30:23];
    t_sig = {|tensor_i[30:23], tensor_i[22:0]};
    s_x   = $signed({8'b0, s_exp}) - 12'sd10;
    t_x   = $signed({4'b0, t_exp}) - 12'sd150;
    if (mode_i == MODE_FP8) begin
      sign_o = nib_i[3] ^ scale_i[7] ^ tensor_i[31];
      nan_o  = (scale_i[6:0] == 7'h7F) || (tensor_i[30:23] == 8'hFF);
      sig_o  = {28'b0, w_sig} * {28'b0, s_sig} * {8'b0, t_sig};
      exp_o  = s_x + t_x - 12'sd1;
    end else begin
      sign_o = nib_i[3];
      nan_o  = (scale_i == 8'hFF);
      sig_o  = {28'b0, w_sig};
      exp_o  = $signed({4'b0, scale_i}) - 12'sd128;
    end
  end
endmodule

// File: rtl/fp4dq_round16.sv
module fp4dq_round16
  import fp4dq_pkg::*;
(
  input  logic               sign_i,
  input  logic               nan_i,
  input  logic [31:0]        sig_i,
  input  logic signed [11:0] exp_i,
  output logic [15:0]        half_o
);
  int          lead, e_unb, e_q, sh, bits;
  logic [31:0] q32, hsh, mask;
  logic        rnd, sticky;

  always_comb begin
    lead = 0;
    for (int i = 0; i < 32; i++) if (sig_i[i]) lead = i;
    e_unb  = lead + int'(exp_i);
    e_q    = (e_unb < -14) ? -14 : e_unb;
    sh     = (e_q - 10) - int'(exp_i);
    rnd    = 1'b0;
    sticky = 1'b0;
    hsh    = '0;
    mask   = '0;
    if (sh <= 0) begin
      q32 = sig_i << (-sh);
    end else if (sh > 32) begin
      q32 = '0;
    end else begin
      hsh    = sig_i >> (sh - 1);
      mask   = (32'h1 << (sh - 1)) - 32'h1;
      rnd    = hsh[0];
      sticky = |(sig_i & mask);
      q32    = hsh >> 1;
    end
    q32  = q32 + {31'b0, rnd && (sticky || q32[0])};
    bits = ((e_q + 14) * 1024) + int'(q32[11:0]);
    if (nan_i)                half_o = HALF_QNAN;
    else if (sig_i == 32'd0)  half_o = {sign_i, 15'h0};
    else if (e_unb > 15)      half_o = {sign_i, HALF_MAXMAG};
    else if (bits >= 'h7C00)  half_o = {sign_i, HALF_MAXMAG};
    else                      half_o = {sign_i, bits[14:0]};
  end
endmodule

// File: rtl/fp4_block_dequant.sv
module fp4_block_dequant
  import fp4dq_pkg::*;
#(
  parameter int EXP_GROUP = 32,
  parameter int FP8_GROUP = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_i,
  input  logic [31:0] tensor_scale_i,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data
);
  logic        adv, emit, sc_sign, sc_nan;
  logic [3:0]  nib;
  logic [7:0]  scale;
  scale_mode_e mode;
  logic [31:0] sc_sig;
  logic signed [11:0] sc_exp;
  logic [15:0] half;

  assign adv = !out_valid || out_ready;

  fp4dq_ctrl #(.EXP_GROUP(EXP_GROUP), .FP8_GROUP(FP8_GROUP)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .adv_i(adv), .emit_o(emit), .nib_o(nib), .scale_o(scale), .mode_o(mode)
  );

  fp4dq_scale scale_i (
    .mode_i(mode), .nib_i(nib), .scale_i(scale), .tensor_i(tensor_scale_i),
    .sign_o(sc_sign), .nan_o(sc_nan), .sig_o(sc_sig), .exp_o(sc_exp)
  );

  fp4dq_round16 round_i (
    .sign_i(sc_sign), .nan_i(sc_nan), .sig_i(sc_sig), .exp_i(sc_exp), .half_o(half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 16'h0;
    end else if (adv) begin
      out_valid <= emit;
      if (emit) out_data <= half;
    end
  end
endmodule

// File: rtl/fp4_block_dequant_chk.sv
module fp4_block_dequant_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data
);
  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  assert_no_infinity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((out_data[14:10] == 5'h1F) && (out_data[9:0] == 10'h0)));

  // R5 and R6: the only all-ones-exponent code ever emitted is the quiet NaN
  assert_canonical_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_data[14:10] == 5'h1F) |-> out_data == 16'h7E00);
endmodule

bind fp4_block_dequant fp4_block_dequant_chk chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fp4_block_dequant_tb_top.sv
module fp4_block_dequant_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] tensor_scale_i = 32'h3F800000;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  always #10 clk = ~clk;

  fp4_block_dequant dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tensor_scale_i(tensor_scale_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int n_tests = 0, n_fail = 0, cyc = 0, first_cyc = 0, last_cyc = 0;
  logic [7:0]  in_bytes[$];
  logic        in_modes[$];
  logic [15:0] exp_vals[$];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  function automatic real p2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real wmag(input logic [2:0] c);
    case (c)
      3'd0: return 0.0;  3'd1: return 0.5;  3'd2: return 1.0;  3'd3: return 1.5;
      3'd4: return 2.0;  3'd5: return 3.0;  3'd6: return 4.0;  default: return 6.0;
    endcase
  endfunction

  function automatic logic [15:0] to_half(input bit s, input real v);
    int e, eq, q, bits;
    real qf, fl;
    if (v == 0.0) return {s, 15'h0};
    e = 0;
    while (v >= p2(e + 1)) e++;
    while (v < p2(e)) e--;
    if (e > 15) return {s, 15'h7BFF};
    eq = (e < -14) ? -14 : e;
    qf = v / p2(eq - 10);
    fl = $floor(qf);
    q  = int'(fl);
    if ((qf - fl > 0.5) || ((qf - fl == 0.5) && (q % 2 == 1))) q++;
    bits = (eq + 14) * 1024 + q;
    if (bits >= 'h7C00) return {s, 15'h7BFF};
    return {s, bits[14:0]};
  endfunction

  function automatic logic [15:0] ref_out(input bit fp8, input logic [7:0] sc,
                                          input logic [3:0] nib, input logic [31:0] ts);
    bit  s = nib[3];
    real v = wmag(nib[2:0]);
    int  se, sm, te, tm;
    if (!fp8) begin
      if (sc == 8'hFF) return 16'h7E00;
      return to_half(s, v * p2(int'(sc) - 127));
    end
    if (sc[6:0] == 7'h7F || ts[30:23] == 8'hFF) return 16'h7E00;
    s  = s ^ sc[7] ^ ts[31];
    se = int'(sc[6:3]);  sm = int'(sc[2:0]);
    te = int'(ts[30:23]); tm = int'(ts[22:0]);
    v = v * ((se == 0) ? real'(sm) / 8.0 * p2(-6) : (1.0 + real'(sm) / 8.0) * p2(se - 7));
    v = v * ((te == 0) ? real'(tm) * p2(-149) : (1.0 + real'(tm) * p2(-23)) * p2(te - 127));
    return to_half(s, v);
  endfunction

  // one group: scale byte with its mode, data bytes carry the opposite mode (R3)
  task automatic push_group(input bit fp8, input logic [7:0] sc, input bit pattern);
    int nb = fp8 ? 8 : 16;
    logic [7:0] b;
    in_bytes.push_back(sc);
    in_modes.push_back(fp8);
    for (int i = 0; i < nb; i++) begin
      if (pattern) b = {4'(15 - i), 4'(i)};
      else begin step_lfsr(); b = lfsr[7:0]; end
      in_bytes.push_back(b);
      in_modes.push_back(!fp8);
      exp_vals.push_back(ref_out(fp8, sc, b[3:0], tensor_scale_i));
      exp_vals.push_back(ref_out(fp8, sc, b[7:4], tensor_scale_i));
    end
  endtask

  task automatic push_bytes(input bit fp8, input logic [7:0] sc, input logic [7:0] d0,
                            input logic [7:0] dfill);
    int nb = fp8 ? 8 : 16;
    in_bytes.push_back(sc);
    in_modes.push_back(fp8);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b = (i == 0) ? d0 : dfill;
      in_bytes.push_back(b);
      in_modes.push_back(!fp8);
      exp_vals.push_back(ref_out(fp8, sc, b[3:0], tensor_scale_i));
      exp_vals.push_back(ref_out(fp8, sc, b[7:4], tensor_scale_i));
    end
  endtask

  task automatic run(input string req, input bit stall);
    int ii = 0, oi = 0, t0 = cyc;
    bit first = 1'b1;
    while (oi < exp_vals.size()) begin
      @(posedge clk); #1;
      if (stall) begin
        step_lfsr();
        out_ready = lfsr[0] | lfsr[3];
        in_valid  = (ii < in_bytes.size()) && (lfsr[5] | lfsr[9]);
      end else begin
        out_ready = 1'b1;
        in_valid  = (ii < in_bytes.size());
      end
      if (ii < in_bytes.size()) begin
        in_data = in_bytes[ii];
        mode_i  = in_modes[ii];
      end
      @(negedge clk);
      if (out_valid && out_ready) begin
        chk(out_data == exp_vals[oi], req, $sformatf("element %0d", oi), out_data, exp_vals[oi]);
        if (first) first_cyc = cyc;
        first = 1'b0;
        last_cyc = cyc;
        oi++;
      end
      if (in_valid && in_ready) ii++;
      if (cyc - t0 > 5000) begin
        chk(1'b0, req, "stream stalled", oi, exp_vals.size());
        break;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    in_bytes.delete(); in_modes.delete(); exp_vals.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_codes();   // R1 R2 R4: every code, both nibble positions, unit scale
    push_group(1'b0, 8'd127, 1'b1);
    run("R1", 1'b0);
    push_bytes(1'b0, 8'd127, 8'h08, 8'h80);   // negative zero in both positions
    run("R2", 1'b0);
  endtask

  task automatic t_exp_groups();   // R3 R4: consecutive groups with new scales
    push_group(1'b0, 8'h85, 1'b0);
    push_group(1'b0, 8'h70, 1'b0);
    push_group(1'b0, 8'h7F, 1'b0);
    run("R3", 1'b0);
  endtask

  task automatic t_exp_nan();
    push_group(1'b0, 8'hFF, 1'b0);
    push_group(1'b0, 8'h80, 1'b0);
    run("R5", 1'b0);
  endtask

  task automatic t_saturate();   // 6*2^14, 4*2^14 saturate; 3*2^14 fits
    push_bytes(1'b0, 8'd141, 8'hE7, 8'h53);
    push_bytes(1'b0, 8'hFE, 8'h2F, 8'h00);
    run("R8", 1'b0);
  endtask

  task automatic t_tiny();   // values near the smallest FP16 subnormal
    push_bytes(1'b0, 8'd103, 8'h21, 8'h93);
    push_bytes(1'b0, 8'd102, 8'hB5, 8'h47);
    push_bytes(1'b0, 8'h50, 8'hF9, 8'h7F);
    run("R7", 1'b0);
  endtask

  task automatic t_fp8();
    tensor_scale_i = 32'h3FC00000;
    push_group(1'b1, 8'h3D, 1'b0);
    push_group(1'b1, 8'hB3, 1'b0);
    push_group(1'b1, 8'h01, 1'b0);
    run("R6", 1'b0);
    tensor_scale_i = 32'hBE2AAAAB;
    push_group(1'b1, 8'h5A, 1'b0);
    run("R6", 1'b0);
  endtask

  task automatic t_fp8_rne();   // ties: 1+2^-11 -> even below, 1+3*2^-11 -> even above
    tensor_scale_i = 32'h3F801000;
    push_bytes(1'b1, 8'h38, 8'h32, 8'h3A);
    run("R7", 1'b0);
    tensor_scale_i = 32'h3F803000;
    push_bytes(1'b1, 8'h38, 8'h72, 8'h52);
    run("R7", 1'b0);
    tensor_scale_i = 32'h3F800FFF;
    push_group(1'b1, 8'h41, 1'b0);
    run("R7", 1'b0);
  endtask

  task automatic t_fp8_special();
    tensor_scale_i = 32'h3F800000;
    push_group(1'b1, 8'h7F, 1'b0);
    push_group(1'b1, 8'hFF, 1'b0);
    run("R6", 1'b0);
    tensor_scale_i = 32'h7FC00000;
    push_group(1'b1, 8'h38, 1'b0);
    run("R6", 1'b0);
    tensor_scale_i = 32'h43800000;   // 448 * 256 * weight: saturates
    push_bytes(1'b1, 8'h7E, 8'hF7, 8'h21);
    run("R8", 1'b0);
  endtask

  task automatic t_backpressure();
    tensor_scale_i = 32'h3E99999A;
    for (int g = 0; g < 6; g++) begin
      push_group(1'b0, 8'd120 + 8'(g), 1'b0);
      push_group(1'b1, 8'h30 + 8'(g), 1'b0);
    end
    run("R9", 1'b1);
  endtask

  task automatic t_throughput();
    tensor_scale_i = 32'h3F800000;
    push_group(1'b0, 8'd127, 1'b0);
    run("R11", 1'b0);
    chk(last_cyc - first_cyc == 31, "R11", "cycles spanned by 32 results",
        last_cyc - first_cyc, 31);
    push_group(1'b1, 8'h38, 1'b0);
    run("R11", 1'b0);
    chk(last_cyc - first_cyc == 15, "R11", "cycles spanned by 16 results",
        last_cyc - first_cyc, 15);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_codes();
    t_exp_groups();
    t_exp_nan();
    t_saturate();
    t_tiny();
    t_fp8();
    t_fp8_rne();
    t_fp8_special();
    t_backpressure();
    t_throughput();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule